// File: doc/BRIEF.md
# AND/OR Event Combiner Matrix

This block merges a vector of event lines, typically raised by address comparators and event counters, into a small set of combined triggers. It has four AND groups and four OR groups. Each group picks its members from the event lines through an 8-bit membership field. An AND group fires while all of its members are high, and an OR group fires while at least one of its members is high. Any group can also contribute to one shared interrupt request.

Membership fields use inverted polarity: a zero bit makes the event line a member and a one bit leaves it out. Interrupt enables use the same polarity, so a zero enables a group. After reset every field is all ones. Every group therefore starts with no members and with its interrupt disabled.

Software configures the block through a one-cycle write port. It can write a whole mask register, or it can reprogram a single group in one command. The single-group command loads that group's field with the inverse of the chosen member list and leaves every other field unchanged.

Top module: `evt_combiner`

## Requirements
- R1: While and after reset, with no configuration written, every group output and `irq` read 0 whatever `evt_in` holds.
- R2: AND group g uses bits [8g+7:8g] of the AND mask register. A 0 at bit 8g+i makes `evt_in[i]` a member. `and_out[g]` is 1 when every member is high.
- R3: An AND group whose field is all ones (no members) outputs 0, even when every event line is high.
- R4: OR group g uses bits [8g+7:8g] of the OR mask register, with the same polarity as the AND groups. `or_out[g]` is 1 when any member is high, and it is 0 when the group has no members.
- R5: Group outputs and `irq` are registered. A change on `evt_in` shows on the outputs only after the next rising clock edge.
- R6: A write with `cfg_op`=0 loads `cfg_data` into the whole AND mask register. `cfg_op`=1 does the same for the OR mask register.
- R7: `cfg_op`=3 reprograms one group. `cfg_data[7:0]` is the member list, `cfg_data[9:8]` the group index, and `cfg_data[10]` selects the family (1 = OR, 0 = AND). The group's field becomes the inverse of the member list, and every other field keeps its value.
- R8: `cfg_op`=2 loads the interrupt masks: `cfg_data[3:0]` for AND groups 0..3 and `cfg_data[7:4]` for OR groups 0..3. A 0 bit enables that group. `irq` is the OR of all registered group outputs whose interrupt is enabled.
- R9: During `cfg_op`=3, `cfg_data[11]`=1 enables the reprogrammed group's interrupt and 0 disables it. The other groups' interrupt masks keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 8 | Event lines from comparators and counters |
| cfg_wr | input | 1 | Configuration write strobe, one cycle |
| cfg_op | input | 2 | Write command: 0 AND mask, 1 OR mask, 2 interrupt masks, 3 program one group |
| cfg_data | input | 32 | Write data, laid out by command |
| and_out | output | 4 | Registered AND group outputs |
| or_out | output | 4 | Registered OR group outputs |
| irq | output | 1 | Registered interrupt request |

## Verification
The AND groups are given overlapping member sets and then driven with four kinds of input: exactly the members, the members plus outsiders, all ones, and a pattern that misses one member. These separate "all members" from "any line" and show that non-members are ignored. The OR groups are driven with single-bit patterns that land inside or outside each group, and an empty group is included to show it stays low. For the interrupt, input patterns raise an enabled group alone and a disabled group alone, which exposes polarity errors in the interrupt masks. Reprogramming one group is followed by patterns that would change its neighbours' outputs if their fields had been touched.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    OP_AND_MASK   = 2'd0,
    OP_OR_MASK    = 2'd1,
    OP_INT_MASK   = 2'd2,
    OP_PROG_GROUP = 2'd3
  } evc_op_e;
endpackage

// File: rtl/evc_cfg_regs.sv
module evc_cfg_regs
  import evc_pkg::*;
#(
  parameter int N_EVT = 8,
  parameter int N_GRP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [1:0]             cfg_op,
  input  logic [N_EVT*N_GRP-1:0] cfg_data,
  output logic [N_EVT*N_GRP-1:0] and_mask_o,
  output logic [N_EVT*N_GRP-1:0] or_mask_o,
  output logic [N_GRP-1:0]       and_imask_o,
  output logic [N_GRP-1:0]       or_imask_o
);
  localparam int MASK_W = N_EVT * N_GRP;
  localparam int GIW    = (N_GRP > 1) ? $clog2(N_GRP) : 1;
  localparam int FAM_B  = N_EVT + GIW;
  localparam int IEN_B  = N_EVT + GIW + 1;

  logic [MASK_W-1:0] and_mask_q, and_mask_d;
  logic [MASK_W-1:0] or_mask_q,  or_mask_d;
  logic [N_GRP-1:0]  and_imask_q, and_imask_d;
  logic [N_GRP-1:0]  or_imask_q,  or_imask_d;

  evc_op_e          op;
  logic [N_EVT-1:0] prog_members;
  logic [GIW-1:0]   prog_grp;
  logic             prog_is_or;
  logic             prog_int_en;

  assign op           = evc_op_e'(cfg_op);
  assign prog_members = cfg_data[N_EVT-1:0];
  assign prog_grp     = cfg_data[N_EVT +: GIW];
  assign prog_is_or   = cfg_data[FAM_B];
  assign prog_int_en  = cfg_data[IEN_B];

  // next-state
  always_comb begin
    and_mask_d  = and_mask_q;
    or_mask_d   = or_mask_q;
    and_imask_d = and_imask_q;
    or_imask_d  = or_imask_q;
    if (cfg_wr) begin
      unique case (op)
        OP_AND_MASK: and_mask_d = cfg_data;
        OP_OR_MASK:  or_mask_d  = cfg_data;
        OP_INT_MASK: begin
          and_imask_d = cfg_data[N_GRP-1:0];
          or_imask_d  = cfg_data[N_GRP +: N_GRP];
        end
        OP_PROG_GROUP: begin
          for (int g = 0; g < N_GRP; g++) begin
            if (prog_grp == GIW'(g)) begin
              if (prog_is_or) begin
                or_mask_d[g*N_EVT +: N_EVT] = ~prog_members;
                or_imask_d[g]               = ~prog_int_en;
              end else begin
                and_mask_d[g*N_EVT +: N_EVT] = ~prog_members;
                and_imask_d[g]               = ~prog_int_en;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_mask_q  <= '1;
      or_mask_q   <= '1;
      and_imask_q <= '1;
      or_imask_q  <= '1;
    end else if (cfg_wr) begin
      and_mask_q  <= and_mask_d;
      or_mask_q   <= or_mask_d;
      and_imask_q <= and_imask_d;
      or_imask_q  <= or_imask_d;
    end
  end

  assign and_mask_o  = and_mask_q;
  assign or_mask_o   = or_mask_q;
  assign and_imask_o = and_imask_q;
  assign or_imask_o  = or_imask_q;

  // R6 whole-register loads
  a_r6_and_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_op == 2'd0) |=> (and_mask_o == $past(cfg_data)));
  a_r6_or_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_op == 2'd1) |=> (or_mask_o == $past(cfg_data)));
  // R7 single-group program: field inverted, other family untouched
  a_r7_prog_and_field: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_op == 2'd3 && !cfg_data[FAM_B]) |=>
      (and_mask_o[$past(cfg_data[N_EVT +: GIW])*N_EVT +: N_EVT] == ~$past(cfg_data[N_EVT-1:0])));
  a_r7_prog_keeps_or: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_op == 2'd3 && !cfg_data[FAM_B]) |=> $stable(or_mask_o));
  a_r7_prog_keeps_and: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_op == 2'd3 && cfg_data[FAM_B]) |=> $stable(and_mask_o));
  // R9 program command sets the group's interrupt enable
  a_r9_prog_or_int: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_op == 2'd3 && cfg_data[FAM_B]) |=>
      (or_imask_o[$past(cfg_data[N_EVT +: GIW])] == !$past(cfg_data[IEN_B])));
  // no write, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(and_mask_o) && $stable(or_mask_o) &&
                 $stable(and_imask_o) && $stable(or_imask_o)));
endmodule

// File: rtl/evc_group.sv
module evc_group #(
  parameter int N_EVT  = 8,
  parameter bit IS_AND = 1'b1
) (
  input  logic [N_EVT-1:0] evt,
  input  logic [N_EVT-1:0] field,
  output logic             hit
);
  logic [N_EVT-1:0] members;
  assign members = ~field;

  generate
    if (IS_AND) begin : g_and
      always_comb hit = (|members) && ((evt & members) == members);
    end else begin : g_or
      always_comb hit = |(evt & members);
    end
  endgenerate
endmodule

// File: rtl/evt_combiner.sv
module evt_combiner #(
  parameter int N_EVT = 8,
  parameter int N_GRP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_EVT-1:0]       evt_in,
  input  logic                   cfg_wr,
  input  logic [1:0]             cfg_op,
  input  logic [N_EVT*N_GRP-1:0] cfg_data,
  output logic [N_GRP-1:0]       and_out,
  output logic [N_GRP-1:0]       or_out,
  output logic                   irq
);
  localparam int MASK_W = N_EVT * N_GRP;

  logic [MASK_W-1:0] and_mask, or_mask;
  logic [N_GRP-1:0]  and_imask, or_imask;
  logic [N_GRP-1:0]  and_hit, or_hit;
  logic [N_GRP-1:0]  and_q, or_q;
  logic              irq_q, irq_d;

  evc_cfg_regs #(.N_EVT(N_EVT), .N_GRP(N_GRP)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_op      (cfg_op),
    .cfg_data    (cfg_data),
    .and_mask_o  (and_mask),
    .or_mask_o   (or_mask),
    .and_imask_o (and_imask),
    .or_imask_o  (or_imask)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    evc_group #(.N_EVT(N_EVT), .IS_AND(1'b1)) u_and (
      .evt   (evt_in),
      .field (and_mask[g*N_EVT +: N_EVT]),
      .hit   (and_hit[g])
    );
    evc_group #(.N_EVT(N_EVT), .IS_AND(1'b0)) u_or (
      .evt   (evt_in),
      .field (or_mask[g*N_EVT +: N_EVT]),
      .hit   (or_hit[g])
    );

    // R3 empty AND group stays low
    a_r3_empty_and: assert property (@(posedge clk) disable iff (!rst_n)
      (and_mask[g*N_EVT +: N_EVT] == '1) |=> !and_out[g]);
    // R2 all members high raises the AND group
    a_r2_and_full: assert property (@(posedge clk) disable iff (!rst_n)
      ((and_mask[g*N_EVT +: N_EVT] != '1) &&
       ((evt_in | and_mask[g*N_EVT +: N_EVT]) == '1)) |=> and_out[g]);
    // R4 any member high raises the OR group
    a_r4_or_any: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_in & ~or_mask[g*N_EVT +: N_EVT])) |=> or_out[g]);
    a_r4_or_none: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(evt_in & ~or_mask[g*N_EVT +: N_EVT])) |=> !or_out[g]);
  end

  // next-state
  always_comb begin
    irq_d = |((and_hit & ~and_imask) | (or_hit & ~or_imask));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_q <= '0;
      or_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      and_q <= and_hit;
      or_q  <= or_hit;
      irq_q <= irq_d;
    end
  end

  assign and_out = and_q;
  assign or_out  = or_q;
  assign irq     = irq_q;

  // R8 interrupt follows enabled registered outputs
  a_r8_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |((and_out & ~$past(and_imask)) | (or_out & ~$past(or_imask)))));
  // R1 reset state
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (and_out == '0 && or_out == '0 && !irq);
    end
  end
endmodule

// File: tb/tb_evt_combiner.sv
module tb_evt_combiner;
  logic        clk;
  logic        rst_n;
  logic [7:0]  evt_in;
  logic        cfg_wr;
  logic [1:0]  cfg_op;
  logic [31:0] cfg_data;
  logic [3:0]  and_out, or_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state kept from the requirements
  logic [31:0] m_and, m_or;
  logic [3:0]  mi_and, mi_or;

  evt_combiner dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_wr(cfg_wr),
    .cfg_op(cfg_op), .cfg_data(cfg_data), .and_out(and_out),
    .or_out(or_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [3:0] exp_and(input logic [7:0] e);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) begin
      logic [7:0] s;
      s = ~m_and[g*8 +: 8];
      r[g] = (s != 8'h00) && ((e & s) == s);
    end
    return r;
  endfunction

  function automatic logic [3:0] exp_or(input logic [7:0] e);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = |(e & ~m_or[g*8 +: 8]);
    return r;
  endfunction

  task automatic compare(input string tag, input logic [3:0] ea,
                         input logic [3:0] eo, input logic ei);
    checks++;
    if (and_out !== ea || or_out !== eo || irq !== ei) begin
      errors++;
      $display("FAIL %s: and=%h or=%h irq=%b expected and=%h or=%h irq=%b",
               tag, and_out, or_out, irq, ea, eo, ei);
    end
  endtask

  // drive events, let one edge pass, compare with reference
  task automatic step(input string tag, input logic [7:0] e);
    logic [3:0] ea, eo;
    @(negedge clk);
    evt_in = e;
    ea = exp_and(e);
    eo = exp_or(e);
    @(negedge clk);
    compare(tag, ea, eo, |((ea & ~mi_and) | (eo & ~mi_or)));
  endtask

  task automatic wr(input logic [1:0] op, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_op = op; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_data = '0;
    case (op)
      2'd0: m_and = d;
      2'd1: m_or  = d;
      2'd2: begin mi_and = d[3:0]; mi_or = d[7:4]; end
      default: begin
        if (d[10]) begin
          m_or[d[9:8]*8 +: 8] = ~d[7:0];
          mi_or[d[9:8]] = ~d[11];
        end else begin
          m_and[d[9:8]*8 +: 8] = ~d[7:0];
          mi_and[d[9:8]] = ~d[11];
        end
      end
    endcase
  endtask

  function automatic logic [31:0] prog(input bit ien, input bit is_or,
                                       input logic [1:0] g, input logic [7:0] mem);
    return {20'd0, ien, is_or, g, mem};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; evt_in = 8'hFF; cfg_wr = 1'b0; cfg_op = 2'd0; cfg_data = '0;
    m_and = '1; m_or = '1; mi_and = '1; mi_or = '1;
    repeat (3) @(negedge clk);
    compare("R1 in reset", 4'h0, 4'h0, 1'b0);
    rst_n = 1'b1;
    step("R1 after reset all high", 8'hFF);
    step("R3 empty groups after reset", 8'h5A);
  endtask

  task automatic t_and();
    wr(2'd3, prog(0, 0, 2'd0, 8'h0F));
    wr(2'd3, prog(0, 0, 2'd1, 8'h80));
    wr(2'd3, prog(0, 0, 2'd2, 8'hFF));
    step("R2 exact members", 8'h0F);
    step("R2 members plus outsiders", 8'h8F);
    step("R2 all lines high", 8'hFF);
    step("R2 one member missing", 8'h7E);
    step("R3 group3 empty idle", 8'h00);
    wr(2'd0, 32'hFFFF_00FE);
    step("R6 whole AND write", 8'h01);
    step("R6 whole AND write group1", 8'hFF);
  endtask

  task automatic t_or();
    wr(2'd1, 32'h00FF_0FFE);
    step("R4 no lines", 8'h00);
    step("R4 line0", 8'h01);
    step("R4 line5", 8'h20);
    step("R4 line7 empty group2 low", 8'h80);
    wr(2'd3, prog(0, 1, 2'd1, 8'h03));
    step("R7 reprogram OR1 new member", 8'h02);
    step("R7 reprogram OR1 old member gone", 8'h20);
    step("R7 AND fields untouched", 8'hFF);
  endtask

  task automatic t_irq();
    wr(2'd2, 32'h0000_00FE);
    step("R8 enabled AND0 raises irq", 8'h01);
    step("R8 disabled OR groups keep irq low", 8'h80);
    wr(2'd3, prog(1, 1, 2'd3, 8'h80));
    step("R9 prog enables OR3 irq", 8'h80);
    wr(2'd3, prog(0, 0, 2'd0, 8'h01));
    step("R9 prog disables AND0 irq", 8'h01);
    step("R9 OR3 enable kept", 8'h80);
  endtask

  task automatic t_latency();
    logic [3:0] old_a, old_o;
    logic       old_i;
    step("R5 baseline", 8'h00);
    old_a = and_out; old_o = or_out; old_i = irq;
    @(negedge clk);
    evt_in = 8'h80;
    #2;
    compare("R5 no change before edge", old_a, old_o, old_i);
    @(negedge clk);
    compare("R5 change after edge", exp_and(8'h80), exp_or(8'h80),
            |((exp_and(8'h80) & ~mi_and) | (exp_or(8'h80) & ~mi_or)));
  endtask

  initial begin
    t_reset();
    t_and();
    t_or();
    t_irq();
    t_latency();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule